// File: doc/BRIEF.md
# Branch Condition Evaluator

This unit decides, within one combinational path, whether a conditional branch is taken. A 4-bit condition selector picks one of sixteen tests. Each test is built from five status flags: sign, overflow, carry, a zero flag for the full 16-bit word and a zero flag for the low byte alone. The eight even/odd pairs that differ only in selector bit 1 are exact opposites of each other.

The unit has two modes. In flag mode the tests use the flag inputs and those flags pass through to the flag outputs unchanged. In compare mode the second operand is subtracted from the first, fresh flags are formed from the difference, and the selected test is applied to those fresh flags in the same cycle. The fresh flags are also driven out so that a caller can write them back to its status word. The unit has no clock and no state.

Top module: `branch_cond_eval`

## Requirements
- R1: Selector 0 is taken when sign equals overflow (signed greater-or-equal). Selector 2 is taken when they differ (signed less-than).
- R2: Selector 1 is taken when carry is 0. Selector 3 is taken when carry is 1.
- R3: Selector 4 is taken when sign XOR overflow is 0 and the word zero flag is 0. Selector 6 is taken when sign XOR overflow is 1 or the word zero flag is 1.
- R4: Selector 5 is taken when carry and word zero are both 0. Selector 7 is taken when either of them is 1.
- R5: Selectors 8 and 10 are taken on sign 0 and sign 1. Selectors 9 and 11 are taken on overflow 0 and overflow 1.
- R6: Selectors 12 and 14 are taken on byte zero 0 and byte zero 1. Selectors 13 and 15 are taken on word zero 0 and word zero 1.
- R7: With cmp_en_i at 0, each flag output equals its flag input, and the operand inputs have no effect on any output.
- R8: With cmp_en_i at 1, taken_o is evaluated on the flags computed from opa_i minus opb_i. The five flag inputs have no effect on any output.
- R9: In compare mode, carry_o is 1 exactly when opa_i is below opb_i as unsigned numbers (a borrow). ovf_o is 1 when the signed subtraction overflows. sign_o is bit 15 of the difference.
- R10: In compare mode, zero_o is 1 when the 16-bit difference is zero. zero_lo_o is 1 when bits 7:0 of the difference are zero.
- R11: For any flags, two selectors that differ only in bit 1 give opposite taken_o values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cond_i | input | 4 | Condition selector |
| cmp_en_i | input | 1 | 1 selects compare mode |
| opa_i | input | 16 | First compare operand (minuend) |
| opb_i | input | 16 | Second compare operand (subtrahend) |
| sign_i | input | 1 | Sign flag in |
| ovf_i | input | 1 | Overflow flag in |
| carry_i | input | 1 | Carry/borrow flag in |
| zero_i | input | 1 | Word zero flag in |
| zero_lo_i | input | 1 | Low-byte zero flag in |
| taken_o | output | 1 | Branch taken |
| sign_o | output | 1 | Effective sign flag |
| ovf_o | output | 1 | Effective overflow flag |
| carry_o | output | 1 | Effective carry flag |
| zero_o | output | 1 | Effective word zero flag |
| zero_lo_o | output | 1 | Effective low-byte zero flag |

## Verification
In flag mode, every selector is tried against all 32 flag combinations. This exposes any swapped polarity, any wrong flag pairing, and any mix-up between the byte zero and word zero flags. Compare mode is tried with several operand pairs:
- equal operands;
- an unsigned borrow;
- both signed overflow directions;
- a difference whose low byte is zero but whose upper byte is not, which separates the two zero flags;
- random pairs.

In both modes the unused inputs are driven with random values to show that they are ignored. A final sweep drives each selector and its bit-1 partner against the same flags and checks that the results are opposite.

// File: rtl/bce_pkg.sv
package bce_pkg;
  localparam int unsigned COND_W   = 4;
  localparam int unsigned NUM_COND = 1 << COND_W;

  typedef struct packed {
    logic sign;
    logic ovf;
    logic carry;
    logic zero;
    logic zero_lo;
  } flags_t;
endpackage

// File: rtl/bce_cmp_flags.sv
module bce_cmp_flags
  import bce_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LO_W   = 8
) (
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output flags_t            flags_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W:0]   wide;
  logic [DATA_W-1:0] diff;

  assign wide = {1'b0, opa_i} - {1'b0, opb_i};
  assign diff = wide[DATA_W-1:0];

  always_comb begin
    flags_o.sign    = diff[MSB];
    flags_o.carry   = wide[DATA_W];
    flags_o.ovf     = (opa_i[MSB] ^ opb_i[MSB]) & (opa_i[MSB] ^ diff[MSB]);
    flags_o.zero    = ~|diff;
    flags_o.zero_lo = ~|diff[LO_W-1:0];
  end

  always_comb begin
    p_borrow_r9: assert (flags_o.carry == (opa_i < opb_i));
    p_signed_lt_r9: assert ((flags_o.sign ^ flags_o.ovf) == ($signed(opa_i) < $signed(opb_i)));
    p_zero_nests_r10: assert (!flags_o.zero || flags_o.zero_lo);
  end
endmodule

// File: rtl/bce_flag_sel.sv
module bce_flag_sel
  import bce_pkg::*;
(
  input  logic   cmp_en_i,
  input  flags_t ext_i,
  input  flags_t cmp_i,
  output flags_t flags_o
);
  assign flags_o = cmp_en_i ? cmp_i : ext_i;
endmodule

// File: rtl/bce_cond_eval.sv
module bce_cond_eval
  import bce_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  flags_t            flags_i,
  output logic              taken_o
);
  logic [NUM_COND-1:0] tbl;
  logic                lt;

  assign lt = flags_i.sign ^ flags_i.ovf;

  // selector bit 1 is polarity; bits 3,2,0 pick the base predicate
  for (genvar k = 0; k < NUM_COND; k++) begin : g_cond
    localparam bit HI  = ((k >> 3) & 1) == 1;
    localparam bit MID = ((k >> 2) & 1) == 1;
    localparam bit LSB = (k & 1) == 1;
    localparam bit POS = ((k >> 1) & 1) == 1;
    logic base;
    if (!HI && !MID && !LSB) begin : g_lt
      assign base = lt;
    end else if (!HI && !MID && LSB) begin : g_c
      assign base = flags_i.carry;
    end else if (!HI && MID && !LSB) begin : g_le
      assign base = lt | flags_i.zero;
    end else if (!HI && MID && LSB) begin : g_ls
      assign base = flags_i.carry | flags_i.zero;
    end else if (HI && !MID && !LSB) begin : g_s
      assign base = flags_i.sign;
    end else if (HI && !MID && LSB) begin : g_v
      assign base = flags_i.ovf;
    end else if (HI && MID && !LSB) begin : g_zb
      assign base = flags_i.zero_lo;
    end else begin : g_z
      assign base = flags_i.zero;
    end
    assign tbl[k] = POS ? base : ~base;
  end

  assign taken_o = tbl[cond_i];

  always_comb begin
    p_pair_r11: assert (taken_o != tbl[cond_i ^ 4'd2]);
  end
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import bce_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LO_W   = 8
) (
  input  logic [3:0]        cond_i,
  input  logic              cmp_en_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              sign_i,
  input  logic              ovf_i,
  input  logic              carry_i,
  input  logic              zero_i,
  input  logic              zero_lo_i,
  output logic              taken_o,
  output logic              sign_o,
  output logic              ovf_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic              zero_lo_o
);
  flags_t ext_flags, cmp_flags, eff_flags;

  assign ext_flags = '{sign: sign_i, ovf: ovf_i, carry: carry_i,
                       zero: zero_i, zero_lo: zero_lo_i};

  bce_cmp_flags #(.DATA_W(DATA_W), .LO_W(LO_W)) u_cmp (
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .flags_o (cmp_flags)
  );

  bce_flag_sel u_sel (
    .cmp_en_i (cmp_en_i),
    .ext_i    (ext_flags),
    .cmp_i    (cmp_flags),
    .flags_o  (eff_flags)
  );

  bce_cond_eval u_eval (
    .cond_i  (cond_i),
    .flags_i (eff_flags),
    .taken_o (taken_o)
  );

  assign sign_o    = eff_flags.sign;
  assign ovf_o     = eff_flags.ovf;
  assign carry_o   = eff_flags.carry;
  assign zero_o    = eff_flags.zero;
  assign zero_lo_o = eff_flags.zero_lo;

  always_comb begin
    p_cmp_eq_r8: assert (!(cmp_en_i && cond_i == 4'd15) || (taken_o == (opa_i == opb_i)));
    p_cmp_borrow_r2: assert (!(cmp_en_i && cond_i == 4'd3) || (taken_o == (opa_i < opb_i)));
    p_flag_nz_r6: assert (cmp_en_i || cond_i != 4'd13 || (taken_o == !zero_i));
    p_pass_r7: assert (cmp_en_i || (carry_o == carry_i && zero_lo_o == zero_lo_i));
  end
endmodule

// File: tb/branch_cond_eval_test.sv
module branch_cond_eval_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]  cond;
  logic        cmp_en;
  logic [15:0] opa, opb;
  logic        s_i, v_i, c_i, z_i, zb_i;
  logic        taken, s_o, v_o, c_o, z_o, zb_o;

  branch_cond_eval uut (
    .cond_i(cond), .cmp_en_i(cmp_en), .opa_i(opa), .opb_i(opb),
    .sign_i(s_i), .ovf_i(v_i), .carry_i(c_i), .zero_i(z_i), .zero_lo_i(zb_i),
    .taken_o(taken), .sign_o(s_o), .ovf_o(v_o), .carry_o(c_o),
    .zero_o(z_o), .zero_lo_o(zb_o)
  );

  typedef struct {
    logic       taken;
    logic [4:0] flags;
    string      ttag;
    string      ftag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic ref_taken(input logic [3:0] cd, input logic [4:0] f);
    logic s, v, c, z, zb;
    {s, v, c, z, zb} = f;
    case (cd)
      4'd0:  return s == v;
      4'd2:  return s != v;
      4'd1:  return !c;
      4'd3:  return c;
      4'd4:  return (s == v) && !z;
      4'd6:  return (s != v) || z;
      4'd5:  return !c && !z;
      4'd7:  return c || z;
      4'd8:  return !s;
      4'd10: return s;
      4'd9:  return !v;
      4'd11: return v;
      4'd12: return !zb;
      4'd14: return zb;
      4'd13: return !z;
      default: return z;
    endcase
  endfunction

  function automatic string cond_tag(input logic [3:0] cd);
    case (cd)
      4'd0, 4'd2: return "R1";
      4'd1, 4'd3: return "R2";
      4'd4, 4'd6: return "R3";
      4'd5, 4'd7: return "R4";
      4'd8, 4'd9, 4'd10, 4'd11: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [4:0] ref_cmp(input logic [15:0] a, input logic [15:0] b);
    int sa, sb, sd;
    logic [15:0] d;
    d  = a - b;
    sa = int'($signed(a));
    sb = int'($signed(b));
    sd = sa - sb;
    return {d[15], (sd > 32767 || sd < -32768), (a < b), (d == 16'd0), (d[7:0] == 8'd0)};
  endfunction

  // driver: apply at posedge, queue expectation
  task automatic drive(input logic [3:0] cd, input logic ce, input logic [15:0] a,
                       input logic [15:0] b, input logic [4:0] fin,
                       input string tt, input string ft);
    item_t it;
    logic [4:0] eff;
    @(posedge clk);
    cond = cd; cmp_en = ce; opa = a; opb = b;
    {s_i, v_i, c_i, z_i, zb_i} = fin;
    eff = ce ? ref_cmp(a, b) : fin;
    it.taken = ref_taken(cd, eff);
    it.flags = eff;
    it.ttag  = tt;
    it.ftag  = ft;
    q.push_back(it);
  endtask

  // monitor: compare at negedge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (taken !== it.taken) begin
        fails++;
        $display("FAIL %s cond=%0d taken act=%b exp=%b", it.ttag, cond, taken, it.taken);
      end
      checks++;
      if ({s_o, v_o, c_o, z_o, zb_o} !== it.flags) begin
        fails++;
        $display("FAIL %s flags act=%b exp=%b", it.ftag, {s_o, v_o, c_o, z_o, zb_o}, it.flags);
      end
    end
  end

  task automatic cmp_all(input logic [15:0] a, input logic [15:0] b);
    for (int k = 0; k < 16; k++)
      drive(4'(k), 1'b1, a, b, 5'($urandom), "R8", "R9 R10");
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog act=%0d exp<=100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cond = '0; cmp_en = 1'b0; opa = '0; opb = '0;
    {s_i, v_i, c_i, z_i, zb_i} = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // idle state: all-zero inputs
    drive(4'd0, 1'b0, 16'h0, 16'h0, 5'b0, "R1", "R7");

    // flag mode exhaustive, operands random (R7)
    for (int k = 0; k < 16; k++)
      for (int f = 0; f < 32; f++)
        drive(4'(k), 1'b0, 16'($urandom), 16'($urandom), 5'(f), cond_tag(4'(k)), "R7");

    // compare mode corners (R8, R9, R10)
    cmp_all(16'h1234, 16'h1234);
    cmp_all(16'h0003, 16'h0005);
    cmp_all(16'h8000, 16'h0001);
    cmp_all(16'h7FFF, 16'hFFFF);
    cmp_all(16'h0100, 16'h0000);
    cmp_all(16'h5A00, 16'h3400);
    cmp_all(16'hFFFF, 16'h0000);
    for (int n = 0; n < 40; n++) cmp_all(16'($urandom), 16'($urandom));

    repeat (2) @(posedge clk);

    // R11: bit-1 partners opposite under identical flags
    for (int f = 0; f < 32; f++)
      for (int k = 0; k < 16; k++) begin
        logic t0;
        if (k[1]) continue;
        @(posedge clk);
        cmp_en = 1'b0; cond = 4'(k); {s_i, v_i, c_i, z_i, zb_i} = 5'(f);
        @(negedge clk); t0 = taken;
        @(posedge clk); cond = 4'(k | 2);
        @(negedge clk);
        checks++;
        if (taken === t0 || $isunknown(taken)) begin
          fails++;
          $display("FAIL R11 cond=%0d act=%b exp=%b", k | 2, taken, ~t0);
        end
      end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule